// File: doc/BRIEF.md
# Dual Pulse-Clocked JK Storage Element

The block provides two independent JK storage channels that run in a fast system-clock domain. Each channel has its own slow pulse clock, which the block treats as a sampled signal. A master stage takes the next state from J and K when the synchronized pulse clock goes high. The channel outputs take the master value only when the synchronized pulse goes low again. So one complete high pulse is needed for the outputs to move. Each channel also has two active-low overrides that force the outputs straight away. A per-channel sticky flag reports J or K moving while the pulse is high.

Each channel is a small state machine with three states:

- `CH_IDLE`: the pulse is low and the outputs are isolated from the master.
- `CH_ARMED`: the pulse is high, the master is frozen, and J and K are ignored.
- `CH_FORCED`: an override is active.

It has these transitions:

- *capture* (`CH_IDLE`→`CH_ARMED`): the synchronized pulse is high; the master is loaded.
- *transfer* (`CH_ARMED`→`CH_IDLE`): the synchronized pulse is low; the outputs take the master value.
- *force* (any state→`CH_FORCED`): the set or reset override is low.
- *release-low* (`CH_FORCED`→`CH_IDLE`): the overrides are released while the synchronized pulse is low.
- *release-high* (`CH_FORCED`→`CH_ARMED`): the overrides are released while the synchronized pulse is high. There is no capture on this path.

Top module: `jk_ms_pair_top`

## Requirements
- R1: A synchronous active-high `sys_rst` gives `ch_q`=0, `ch_qn`=1 and `ch_flag`=0 on every channel, and it zeroes the master.
- R2: The channels are independent. Stimulus on one channel never changes the outputs or the flag of the other.
- R3: The master takes its next state from J, K and the present output in the cycle the synchronized pulse is first seen high. The encoding is {J,K}: 00 holds, 10 sets, 01 clears, and 11 complements.
- R4: The outputs change only on a transfer. The new value appears on the third rising `sys_clk` edge after the pulse pin is sampled low: two synchronizer flops, then the transfer register. The outputs never change on the rising side of the pulse.
- R5: While the channel is in `CH_ARMED`, changes on J and K have no effect on the value delivered at the next transfer.
- R6: With J=K=1, the output complements exactly once for each complete high pulse.
- R7: `ch_set_n` low with `ch_rst_n` high makes `ch_q`=1 and `ch_qn`=0 in the same cycle, whatever the pulse, J and K are. It also loads the master and the output state with 1.
- R8: `ch_rst_n` low with `ch_set_n` high makes `ch_q`=0 and `ch_qn`=1 in the same cycle. It also loads the master and the output state with 0.
- R9: Both overrides low drive `ch_q`=1 and `ch_qn`=1. After both are released, the outputs show the value the master held, as true and complement.
- R10: `ch_flag` sets when J or K differs from its value in the previous cycle while the channel is in `CH_ARMED`. It stays set until `ch_flag_clr` is high at a clock edge. When both occur together, the clear wins.
- R11: A release with the synchronized pulse high enters `CH_ARMED` without a capture. The outputs keep the forced value through the following transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| ch_pulse | input | NCH | Pulse clock of each channel (asynchronous) |
| ch_j | input | NCH | J input of each channel |
| ch_k | input | NCH | K input of each channel |
| ch_set_n | input | NCH | Active-low force-to-one override |
| ch_rst_n | input | NCH | Active-low force-to-zero override |
| ch_flag_clr | input | NCH | Clears the sticky violation flag |
| ch_q | output | NCH | True output |
| ch_qn | output | NCH | Complement output |
| ch_flag | output | NCH | Sticky J/K-change-while-high flag |

## Verification
All four {J,K} codes are applied through complete pulses, and toggle is run on back-to-back pulses. This separates hold, set, clear and a single complement per pulse from a double toggle or a capture on the wrong side of the pulse. The two channels get different codes at the same time, which exposes any crossover between them. J and K are moved during the high phase to show that they are ignored there and that they raise the flag. The overrides are applied alone, together, and released while the pulse is high. This tells apart immediate forcing, the master seen after a double override, and the no-capture release path.

// File: rtl/jkms_pkg.sv
package jkms_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ARMED  = 2'd1,
        CH_FORCED = 2'd2
    } ch_state_e;

    // Next stored value from the JK code and the present output.
    function automatic logic jk_next(input logic j, input logic k, input logic cur);
        logic r;
        unique case ({j, k})
            2'b00:   r = cur;
            2'b10:   r = 1'b1;
            2'b01:   r = 1'b0;
            default: r = ~cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jkms_sync.sv
module jkms_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {sr_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/jkms_channel.sv
module jkms_channel
    import jkms_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic j,
    input  logic k,
    input  logic set_n,
    input  logic rst_n,
    input  logic flag_clr,
    output logic q,
    output logic qn,
    output logic flag
);
    ch_state_e state_q, state_d;
    logic      master_q, master_d;
    logic      slave_q, slave_d;
    logic      j_prev_q, k_prev_q;
    logic      flag_q;
    logic      ovr_any;

    assign ovr_any = ~set_n | ~rst_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CH_IDLE;
            master_q <= 1'b0;
            slave_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            master_q <= master_d;
            slave_q  <= slave_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        master_d = master_q;
        slave_d  = slave_q;
        if (ovr_any) begin
            state_d = CH_FORCED;
            if (!set_n && rst_n) begin
                master_d = 1'b1;
                slave_d  = 1'b1;
            end else if (set_n && !rst_n) begin
                master_d = 1'b0;
                slave_d  = 1'b0;
            end else begin
                slave_d  = master_q;
            end
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (lvl) begin
                        state_d  = CH_ARMED;
                        master_d = jk_next(j, k, slave_q);
                    end
                end
                CH_ARMED: begin
                    if (!lvl) begin
                        state_d = CH_IDLE;
                        slave_d = master_q;
                    end
                end
                CH_FORCED: begin
                    state_d = lvl ? CH_ARMED : CH_IDLE;
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        q  = slave_q;
        qn = ~slave_q;
        if (!set_n) begin
            q  = 1'b1;
            qn = ~rst_n;
        end else if (!rst_n) begin
            q  = 1'b0;
            qn = 1'b1;
        end
    end

    // Sticky violation flag
    always_ff @(posedge clk) begin
        if (rst) begin
            j_prev_q <= 1'b0;
            k_prev_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            j_prev_q <= j;
            k_prev_q <= k;
            if (flag_clr)
                flag_q <= 1'b0;
            else if (state_q == CH_ARMED && (j != j_prev_q || k != k_prev_q))
                flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/jk_ms_pair_top.sv
module jk_ms_pair_top #(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           sys_clk,
    input  logic           sys_rst,
    input  logic [NCH-1:0] ch_pulse,
    input  logic [NCH-1:0] ch_j,
    input  logic [NCH-1:0] ch_k,
    input  logic [NCH-1:0] ch_set_n,
    input  logic [NCH-1:0] ch_rst_n,
    input  logic [NCH-1:0] ch_flag_clr,
    output logic [NCH-1:0] ch_q,
    output logic [NCH-1:0] ch_qn,
    output logic [NCH-1:0] ch_flag
);
    localparam int CW = NCH;

    logic [CW-1:0] lvl;

    generate
        for (genvar c = 0; c < CW; c++) begin : g_ch
            jkms_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (sys_clk),
                .rst (sys_rst),
                .d   (ch_pulse[c]),
                .q   (lvl[c])
            );
            jkms_channel u_chan (
                .clk      (sys_clk),
                .rst      (sys_rst),
                .lvl      (lvl[c]),
                .j        (ch_j[c]),
                .k        (ch_k[c]),
                .set_n    (ch_set_n[c]),
                .rst_n    (ch_rst_n[c]),
                .flag_clr (ch_flag_clr[c]),
                .q        (ch_q[c]),
                .qn       (ch_qn[c]),
                .flag     (ch_flag[c])
            );
        end
    endgenerate
endmodule

// File: rtl/jkms_checker.sv
module jkms_checker #(
    parameter int NCH = 2
) (
    input logic           sys_clk,
    input logic           sys_rst,
    input logic [NCH-1:0] ch_pulse,
    input logic [NCH-1:0] ch_set_n,
    input logic [NCH-1:0] ch_rst_n,
    input logic [NCH-1:0] ch_flag_clr,
    input logic [NCH-1:0] ch_q,
    input logic [NCH-1:0] ch_qn,
    input logic [NCH-1:0] ch_flag
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            a_r7_set_forces: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (!ch_set_n[c] && ch_rst_n[c]) |-> (ch_q[c] && !ch_qn[c]));

            a_r8_reset_forces: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (ch_set_n[c] && !ch_rst_n[c]) |-> (!ch_q[c] && ch_qn[c]));

            a_r9_both_high: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (!ch_set_n[c] && !ch_rst_n[c]) |-> (ch_q[c] && ch_qn[c]));

            a_r4_change_after_low: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (ch_set_n[c] && ch_rst_n[c] && $past(ch_set_n[c]) && $past(ch_rst_n[c])
                 && (ch_q[c] != $past(ch_q[c]))) |-> ($past(ch_pulse[c], 3) == 1'b0));

            a_r10_flag_sticky: assert property (@(posedge sys_clk) disable iff (sys_rst)
                (ch_flag[c] && !ch_flag_clr[c]) |=> ch_flag[c]);

            a_r10_clear_wins: assert property (@(posedge sys_clk) disable iff (sys_rst)
                ch_flag_clr[c] |=> !ch_flag[c]);
        end
    endgenerate
endmodule

bind jk_ms_pair_top jkms_checker #(.NCH(NCH)) u_jkms_chk (
    .sys_clk     (sys_clk),
    .sys_rst     (sys_rst),
    .ch_pulse    (ch_pulse),
    .ch_set_n    (ch_set_n),
    .ch_rst_n    (ch_rst_n),
    .ch_flag_clr (ch_flag_clr),
    .ch_q        (ch_q),
    .ch_qn       (ch_qn),
    .ch_flag     (ch_flag)
);

// File: tb/jk_ms_pair_top_tb_top.sv
module jk_ms_pair_top_tb_top;
    localparam int NCH = 2;

    logic           sys_clk = 1'b0;
    logic           sys_rst = 1'b1;
    logic [NCH-1:0] ch_pulse = '0, ch_j = '0, ch_k = '0;
    logic [NCH-1:0] ch_set_n = '1, ch_rst_n = '1, ch_flag_clr = '0;
    logic [NCH-1:0] ch_q, ch_qn, ch_flag;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R1";

    always #10 sys_clk = ~sys_clk;

    jk_ms_pair_top #(.NCH(NCH)) dut_i (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .ch_pulse(ch_pulse),
        .ch_j(ch_j), .ch_k(ch_k), .ch_set_n(ch_set_n), .ch_rst_n(ch_rst_n),
        .ch_flag_clr(ch_flag_clr), .ch_q(ch_q), .ch_qn(ch_qn), .ch_flag(ch_flag)
    );

    // Behavioural reference: pulse history queue, captured flag, two stored bits.
    bit hist [NCH][$];
    bit m_hi [NCH], m_frc [NCH], m_ms [NCH], m_sl [NCH];
    bit m_jp [NCH], m_kp [NCH], m_fl [NCH];

    always @(posedge sys_clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (sys_rst) begin
                hist[c] = {1'b0, 1'b0};
                m_hi[c] = 0; m_frc[c] = 0; m_ms[c] = 0; m_sl[c] = 0;
                m_jp[c] = 0; m_kp[c] = 0; m_fl[c] = 0;
            end else begin
                bit seen;
                seen = hist[c][0];
                if (!m_frc[c] && m_hi[c] && (ch_j[c] != m_jp[c] || ch_k[c] != m_kp[c]))
                    m_fl[c] = 1;
                if (ch_flag_clr[c]) m_fl[c] = 0;
                if (!ch_set_n[c] || !ch_rst_n[c]) begin
                    if (!ch_set_n[c] && ch_rst_n[c])      begin m_ms[c] = 1; m_sl[c] = 1; end
                    else if (ch_set_n[c] && !ch_rst_n[c]) begin m_ms[c] = 0; m_sl[c] = 0; end
                    else m_sl[c] = m_ms[c];
                    m_frc[c] = 1;
                end else if (m_frc[c]) begin
                    m_frc[c] = 0;
                    m_hi[c]  = seen;
                end else if (!m_hi[c] && seen) begin
                    if (ch_j[c] && ch_k[c]) m_ms[c] = !m_sl[c];
                    else if (ch_j[c])       m_ms[c] = 1;
                    else if (ch_k[c])       m_ms[c] = 0;
                    else                    m_ms[c] = m_sl[c];
                    m_hi[c] = 1;
                end else if (m_hi[c] && !seen) begin
                    m_sl[c] = m_ms[c];
                    m_hi[c] = 0;
                end
                m_jp[c] = ch_j[c];
                m_kp[c] = ch_k[c];
                void'(hist[c].pop_front());
                hist[c].push_back(ch_pulse[c]);
            end
        end
    end

    task automatic compare();
        for (int c = 0; c < NCH; c++) begin
            bit eq, eqn;
            eq  = !ch_set_n[c] ? 1'b1 : (!ch_rst_n[c] ? 1'b0 : m_sl[c]);
            eqn = !ch_rst_n[c] ? 1'b1 : (!ch_set_n[c] ? 1'b0 : !m_sl[c]);
            vectors++;
            if (ch_q[c] !== eq || ch_qn[c] !== eqn || ch_flag[c] !== m_fl[c]) begin
                fails++;
                $display("FAIL %s ch%0d t=%0t: q/qn/flag=%b%b%b expected %b%b%b",
                         cur_req, c, $time, ch_q[c], ch_qn[c], ch_flag[c], eq, eqn, m_fl[c]);
            end
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge sys_clk);
            compare();
        end
    endtask

    // One complete pulse on a channel with the given code.
    task automatic pulse(input int c, input bit j, input bit k);
        ch_j[c] = j; ch_k[c] = k;
        tick(2);
        ch_pulse[c] = 1'b1;
        tick(5);
        ch_pulse[c] = 1'b0;
        tick(5);
    endtask

    initial begin
        tick(3);
        cur_req = "R1";
        sys_rst = 1'b0;
        tick(4);

        cur_req = "R3";
        pulse(0, 1, 0);
        pulse(0, 0, 0);
        pulse(0, 0, 1);
        pulse(0, 1, 0);

        // R4: outputs stay put on the rising side, move three edges after the pin falls
        cur_req = "R4";
        ch_j[0] = 0; ch_k[0] = 1; tick(2);
        ch_pulse[0] = 1; tick(6);
        ch_pulse[0] = 0; tick(1); tick(1); tick(1); tick(3);

        cur_req = "R6";
        pulse(0, 1, 1);
        pulse(0, 1, 1);
        pulse(0, 1, 1);

        // R2: both channels pulsed together with different codes
        cur_req = "R2";
        ch_j = 2'b10; ch_k = 2'b10; tick(2);
        ch_pulse = 2'b11; tick(5); ch_pulse = 2'b00; tick(5);
        pulse(1, 0, 1);
        pulse(1, 1, 0);

        // R5 and R10: code moves while high, flag raised, then cleared
        cur_req = "R5";
        ch_j[0] = 1; ch_k[0] = 0; tick(2);
        ch_pulse[0] = 1; tick(5);
        ch_j[0] = 0; ch_k[0] = 1; tick(3);
        ch_pulse[0] = 0; tick(6);
        cur_req = "R10";
        tick(3);
        ch_flag_clr[0] = 1; tick(1); ch_flag_clr[0] = 0; tick(2);

        cur_req = "R7";
        ch_j[0] = 0; ch_k[0] = 1; ch_pulse[0] = 1; tick(3);
        ch_set_n[0] = 0; tick(3);
        ch_pulse[0] = 0; tick(4);
        ch_set_n[0] = 1; tick(4);

        cur_req = "R8";
        ch_rst_n[1] = 0; tick(3);
        ch_rst_n[1] = 1; tick(4);

        cur_req = "R9";
        pulse(0, 0, 1);
        ch_set_n[0] = 0; ch_rst_n[0] = 0; tick(4);
        ch_set_n[0] = 1; ch_rst_n[0] = 1; tick(4);

        cur_req = "R11";
        ch_j[1] = 0; ch_k[1] = 1; ch_pulse[1] = 1; tick(4);
        ch_set_n[1] = 0; tick(3);
        ch_set_n[1] = 1; tick(3);
        ch_pulse[1] = 0; tick(6);
        ch_flag_clr[1] = 1; tick(1); ch_flag_clr[1] = 0; tick(2);

        cur_req = "R1";
        sys_rst = 1; tick(2); sys_rst = 0; tick(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sys_clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule